// File: doc/BRIEF.md
# Debug Port Register Bank

This block is the register file behind a serial-wire style debug port. A host-side link engine presents single-word register accesses: a request strobe, a write flag, a 2-bit word address and 32 bits of write data. Read data comes back on `rdata_o` one cycle after the request. The wire protocol, parity, turnaround and the access ports are outside the block. It only holds state, decodes accesses and exchanges simple signals with its neighbours.

Word 0 returns a fixed identification value on reads. Writes to word 0 go to an abort register that is never stored. Its bits clear individual sticky error flags and can fire a one-cycle abort toward the access-port fabric. Word 1 is banked: a bank field in the select register chooses among the control/status word, a link-control word, the target identity, the link identity and an event-status word. Word 2 is the select register. It also exports the access-port number and the access-port register bank. Word 3 returns the data captured by the most recent access-port read.

The control/status word drives the system power-up, debug power-up and debug reset requests, and reflects their acknowledges. It also holds the overrun detect enable and reports the sticky flags. The sticky flags are overrun, write-data error, transaction error and compare. They can only be set by event inputs and only be cleared through the abort word.

Top module: `dbgp_regs`

## Requirements
- R1: After reset, all sticky flags, the read-OK bit, overrun detect, every request output, the select register (so the bank is 0), the link-control word, `ap_abort_o` and `rdata_o` are 0.
- R2: A read request returns its data on `rdata_o` in the following cycle, and `rdata_o` changes only after a read request. Word 0 returns `ID_VALUE` with bits [15:12] forced to the version value 2.
- R3: A write to word 0 clears the overrun flag (control bit 1) if data bit 4 is 1, the write-data error flag (bit 7) if bit 3 is 1, the error flag (bit 5) if bit 2 is 1, and the compare flag (bit 4) if bit 1 is 1. Several flags may be cleared in one write, and flags whose clear bit is 0 are kept.
- R4: A write to word 0 with data bit 0 set makes `ap_abort_o` high for exactly the next cycle. With bit 0 clear, no pulse is produced.
- R5: In the control word, bits 30, 28 and 26 drive `sys_pwr_req_o`, `dbg_pwr_req_o` and `dbg_rst_req_o`. Bits 31, 29 and 27 read `sys_pwr_ack_i`, `dbg_pwr_ack_i` and `dbg_rst_ack_i`. Bits [11:8] (lane mask), [3:2] (transfer mode) and 0 (overrun detect enable) read back as written. Bits [23:12] read 0.
- R6: `wdata_err_i`, `ap_err_i` and `cmp_evt_i` set control bits 7, 5 and 4. A write of the control word leaves all sticky flags unchanged, whether it writes 1s or 0s to them.
- R7: `overrun_i` sets control bit 1 only while control bit 0 is 1.
- R8: On each `ap_rd_done_i`, control bit 6 takes the value of `ap_rd_ok_i`.
- R9: Select bits [3:0] pick the word at address 1: 0 gives control/status, 1 gives link-control (writable under `LINK_CTRL_MASK`), 2 gives `TARGET_VALUE`, 3 gives `LINK_ID_VALUE`, and 4 gives event status with `event_i` in bit 0. Any other value reads 0. Writes to word 1 take effect only for banks 0 and 1.
- R10: A write to word 2 stores bits [31:24], [7:4] and [3:0]. These appear on `ap_sel_o` and `ap_bank_o`, and the same fields read back with all other bits 0.
- R11: Word 3 returns the `ap_rd_data_i` value captured on the last `ap_rd_done_i`. Repeated reads return the same value and start no access-port activity.
- R12: If a flag's set event and its abort clear arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| sys_pwr_ack_i | input | 1 | System power-up acknowledge |
| dbg_pwr_ack_i | input | 1 | Debug power-up acknowledge |
| dbg_rst_ack_i | input | 1 | Debug reset acknowledge |
| sys_pwr_req_o | output | 1 | System power-up request |
| dbg_pwr_req_o | output | 1 | Debug power-up request |
| dbg_rst_req_o | output | 1 | Debug reset request |
| ap_err_i | input | 1 | Access-port transaction returned an error |
| overrun_i | input | 1 | Overrun event |
| wdata_err_i | input | 1 | Write-data error event |
| cmp_evt_i | input | 1 | Compare event |
| ap_rd_done_i | input | 1 | Access-port read completed |
| ap_rd_ok_i | input | 1 | Completed read responded OK |
| ap_rd_data_i | input | 32 | Completed read data |
| event_i | input | 1 | Event status input shown in bank 4 |
| ap_abort_o | output | 1 | One-cycle abort of the current AP transaction |
| ap_sel_o | output | 8 | Selected access port |
| ap_bank_o | output | 4 | Selected access-port register bank |

## Verification
The control word is written with a fixed mix of request, lane and mode bits. The acknowledge inputs are given an asymmetric pattern, so that a swapped request or acknowledge position shows up on readback. Sticky flags are raised one source at a time. They are then cleared with single-bit and multi-bit abort words, which tells a wrong clear-bit mapping apart from a missing one. The event-and-clear collision is driven in the same cycle. The bank field is stepped through every defined value and one reserved value, and a write is made while a read-only bank is selected. The read buffer is read twice after an OK read and once after a failed read, so that a buffer that does not hold its value, or a read-OK bit stuck at one value, is exposed.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 2;
  localparam int unsigned NUM_STICKY = 4;
  localparam logic [3:0] DP_VERSION = 4'd2;

  // sticky flag indices
  localparam int unsigned FL_ORUN  = 0;
  localparam int unsigned FL_WDERR = 1;
  localparam int unsigned FL_ERR   = 2;
  localparam int unsigned FL_CMP   = 3;

  typedef enum logic [1:0] {
    ADR_ID_ABT = 2'd0,
    ADR_BANKED = 2'd1,
    ADR_SELECT = 2'd2,
    ADR_RDBUF  = 2'd3
  } dp_addr_e;

  typedef enum logic [3:0] {
    BK_CTRL      = 4'd0,
    BK_LINK_CTRL = 4'd1,
    BK_TARGET    = 4'd2,
    BK_LINK_ID   = 4'd3,
    BK_EVENT     = 4'd4
  } dp_bank_e;

  typedef struct packed {
    logic       sys_req;
    logic       dbg_req;
    logic       rst_req;
    logic [3:0] lane_mask;
    logic [1:0] trn_mode;
    logic       orun_en;
  } ctrl_cfg_t;

  typedef struct packed {
    logic [7:0]  ap_sel;
    logic [15:0] rsvd;
    logic [3:0]  ap_bank;
    logic [3:0]  dp_bank;
  } select_t;

  // abort-word bit that clears sticky flag f
  function automatic int unsigned abort_clr_bit(int unsigned f);
    return 4 - f;
  endfunction
endpackage

// File: rtl/dbgp_sticky_flag.sv
module dbgp_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // event beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/dbgp_ctrl_reg.sv
module dbgp_ctrl_reg
  import dbgp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  ctrl_cfg_t wr_cfg_i,
  output ctrl_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_o <= '0;
    else if (wr_en_i) cfg_o <= wr_cfg_i;
  end
endmodule

// File: rtl/dbgp_bank_mux.sv
module dbgp_bank_mux
  import dbgp_pkg::*;
(
  input  logic [3:0]    bank_i,
  input  logic [DW-1:0] ctrl_i,
  input  logic [DW-1:0] link_ctrl_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] link_id_i,
  input  logic [DW-1:0] event_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    case (dp_bank_e'(bank_i))
      BK_CTRL:      data_o = ctrl_i;
      BK_LINK_CTRL: data_o = link_ctrl_i;
      BK_TARGET:    data_o = target_i;
      BK_LINK_ID:   data_o = link_id_i;
      BK_EVENT:     data_o = event_i;
      default:      data_o = '0;
    endcase
  end
endmodule

// File: rtl/dbgp_regs.sv
module dbgp_regs
  import dbgp_pkg::*;
#(
  parameter logic [31:0] ID_VALUE       = 32'h3C11_2A5D,
  parameter logic [31:0] TARGET_VALUE   = 32'h0927_1A3F,
  parameter logic [31:0] LINK_ID_VALUE  = 32'h0000_0001,
  parameter logic [31:0] LINK_CTRL_MASK = 32'h0000_0303
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          sys_pwr_ack_i,
  input  logic          dbg_pwr_ack_i,
  input  logic          dbg_rst_ack_i,
  output logic          sys_pwr_req_o,
  output logic          dbg_pwr_req_o,
  output logic          dbg_rst_req_o,
  input  logic          ap_err_i,
  input  logic          overrun_i,
  input  logic          wdata_err_i,
  input  logic          cmp_evt_i,
  input  logic          ap_rd_done_i,
  input  logic          ap_rd_ok_i,
  input  logic [DW-1:0] ap_rd_data_i,
  input  logic          event_i,
  output logic          ap_abort_o,
  output logic [7:0]    ap_sel_o,
  output logic [3:0]    ap_bank_o
);
  localparam logic [DW-1:0] ID_WORD = {ID_VALUE[31:16], DP_VERSION, ID_VALUE[11:0]};

  logic wr_fire, rd_fire, abort_wr, bank_wr, sel_wr, ctrl_wr, lctl_wr;
  assign wr_fire  = req_i & we_i;
  assign rd_fire  = req_i & ~we_i;
  assign abort_wr = wr_fire && (dp_addr_e'(addr_i) == ADR_ID_ABT);
  assign bank_wr  = wr_fire && (dp_addr_e'(addr_i) == ADR_BANKED);
  assign sel_wr   = wr_fire && (dp_addr_e'(addr_i) == ADR_SELECT);

  select_t sel_q;
  assign ctrl_wr = bank_wr && (dp_bank_e'(sel_q.dp_bank) == BK_CTRL);
  assign lctl_wr = bank_wr && (dp_bank_e'(sel_q.dp_bank) == BK_LINK_CTRL);

  // control configuration
  ctrl_cfg_t cfg_wr, cfg_q;
  assign cfg_wr = '{sys_req:   wdata_i[30],
                    dbg_req:   wdata_i[28],
                    rst_req:   wdata_i[26],
                    lane_mask: wdata_i[11:8],
                    trn_mode:  wdata_i[3:2],
                    orun_en:   wdata_i[0]};

  dbgp_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (ctrl_wr),
    .wr_cfg_i (cfg_wr),
    .cfg_o    (cfg_q)
  );

  // sticky flags
  logic [NUM_STICKY-1:0] flag_set, flags_q;
  assign flag_set[FL_ORUN]  = overrun_i & cfg_q.orun_en;
  assign flag_set[FL_WDERR] = wdata_err_i;
  assign flag_set[FL_ERR]   = ap_err_i;
  assign flag_set[FL_CMP]   = cmp_evt_i;

  for (genvar f = 0; f < NUM_STICKY; f++) begin : g_sticky
    localparam int unsigned CB = abort_clr_bit(f);
    dbgp_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[f]),
      .clr_i  (abort_wr & wdata_i[CB]),
      .flag_o (flags_q[f])
    );
  end

  // state registers
  logic          read_ok_q;
  logic [DW-1:0] rdbuf_q, link_ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      link_ctrl_q <= '0;
      read_ok_q   <= 1'b0;
      rdbuf_q     <= '0;
      ap_abort_o  <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= '{ap_sel: wdata_i[31:24], rsvd: '0,
                             ap_bank: wdata_i[7:4], dp_bank: wdata_i[3:0]};
      if (lctl_wr) link_ctrl_q <= wdata_i & LINK_CTRL_MASK;
      if (ap_rd_done_i) begin
        read_ok_q <= ap_rd_ok_i;
        rdbuf_q   <= ap_rd_data_i;
      end
      ap_abort_o <= abort_wr & wdata_i[0];
    end
  end

  // control/status read image
  logic [DW-1:0] ctrl_word;
  always_comb begin
    ctrl_word        = '0;
    ctrl_word[31]    = sys_pwr_ack_i;
    ctrl_word[30]    = cfg_q.sys_req;
    ctrl_word[29]    = dbg_pwr_ack_i;
    ctrl_word[28]    = cfg_q.dbg_req;
    ctrl_word[27]    = dbg_rst_ack_i;
    ctrl_word[26]    = cfg_q.rst_req;
    ctrl_word[11:8]  = cfg_q.lane_mask;
    ctrl_word[7]     = flags_q[FL_WDERR];
    ctrl_word[6]     = read_ok_q;
    ctrl_word[5]     = flags_q[FL_ERR];
    ctrl_word[4]     = flags_q[FL_CMP];
    ctrl_word[3:2]   = cfg_q.trn_mode;
    ctrl_word[1]     = flags_q[FL_ORUN];
    ctrl_word[0]     = cfg_q.orun_en;
  end

  logic [DW-1:0] banked_word;
  dbgp_bank_mux u_bank_mux (
    .bank_i      (sel_q.dp_bank),
    .ctrl_i      (ctrl_word),
    .link_ctrl_i (link_ctrl_q),
    .target_i    (TARGET_VALUE),
    .link_id_i   (LINK_ID_VALUE),
    .event_i     ({{(DW-1){1'b0}}, event_i}),
    .data_o      (banked_word)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (dp_addr_e'(addr_i))
      ADR_ID_ABT: rd_mux = ID_WORD;
      ADR_BANKED: rd_mux = banked_word;
      ADR_SELECT: rd_mux = sel_q;
      default:    rd_mux = rdbuf_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_fire) rdata_o <= rd_mux;
  end

  assign sys_pwr_req_o = cfg_q.sys_req;
  assign dbg_pwr_req_o = cfg_q.dbg_req;
  assign dbg_rst_req_o = cfg_q.rst_req;
  assign ap_sel_o      = sel_q.ap_sel;
  assign ap_bank_o     = sel_q.ap_bank;
endmodule

// File: rtl/dbgp_regs_chk.sv
module dbgp_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        ap_err_i,
  input logic        overrun_i,
  input logic        wdata_err_i,
  input logic        cmp_evt_i,
  input logic        orun_en,
  input logic [3:0]  flags_q,
  input logic        ap_abort_o,
  input logic        sys_pwr_req_o,
  input logic        dbg_pwr_req_o,
  input logic        dbg_rst_req_o,
  input logic [7:0]  ap_sel_o,
  input logic [3:0]  ap_bank_o
);
  p_rdata_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(req_i && !we_i));

  p_err_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_q[2]) |-> $past(req_i && we_i && addr_i == 2'd0 && wdata_i[2]));

  p_abort_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_abort_o |-> $past(req_i && we_i && addr_i == 2'd0 && wdata_i[0]));

  p_req_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sys_pwr_req_o) || !$stable(dbg_pwr_req_o) || !$stable(dbg_rst_req_o))
      |-> $past(req_i && we_i && addr_i == 2'd1));

  p_err_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[2]) |-> $past(ap_err_i));

  p_wderr_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[1]) |-> $past(wdata_err_i));

  p_cmp_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[3]) |-> $past(cmp_evt_i));

  p_orun_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[0]) |-> $past(overrun_i && orun_en));

  p_sel_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ap_sel_o) || !$stable(ap_bank_o)) |-> $past(req_i && we_i && addr_i == 2'd2));

  p_event_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ap_err_i) |-> flags_q[2]);
endmodule

bind dbgp_regs dbgp_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .ap_err_i      (ap_err_i),
  .overrun_i     (overrun_i),
  .wdata_err_i   (wdata_err_i),
  .cmp_evt_i     (cmp_evt_i),
  .orun_en       (cfg_q.orun_en),
  .flags_q       (flags_q),
  .ap_abort_o    (ap_abort_o),
  .sys_pwr_req_o (sys_pwr_req_o),
  .dbg_pwr_req_o (dbg_pwr_req_o),
  .dbg_rst_req_o (dbg_rst_req_o),
  .ap_sel_o      (ap_sel_o),
  .ap_bank_o     (ap_bank_o)
);

// File: tb/dbgp_regs_test.sv
module dbgp_regs_test;
  localparam logic [31:0] ID_V   = 32'h3C11_2A5D;
  localparam logic [31:0] TGT_V  = 32'h0927_1A3F;
  localparam logic [31:0] LID_V  = 32'h0000_0001;
  localparam logic [31:0] LMASK  = 32'h0000_0303;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sys_ack = 0, dbg_ack = 0, rst_ack = 0;
  logic sys_req, dbg_req, rst_req;
  logic ap_err = 0, overrun = 0, wderr = 0, cmp_evt = 0;
  logic rd_done = 0, rd_ok = 0, evt = 0;
  logic [31:0] rd_data = '0;
  logic abort;
  logic [7:0] ap_sel;
  logic [3:0] ap_bank;

  always #2 clk = ~clk;

  dbgp_regs #(.ID_VALUE(ID_V), .TARGET_VALUE(TGT_V), .LINK_ID_VALUE(LID_V),
              .LINK_CTRL_MASK(LMASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .sys_pwr_ack_i(sys_ack), .dbg_pwr_ack_i(dbg_ack), .dbg_rst_ack_i(rst_ack),
    .sys_pwr_req_o(sys_req), .dbg_pwr_req_o(dbg_req), .dbg_rst_req_o(rst_req),
    .ap_err_i(ap_err), .overrun_i(overrun), .wdata_err_i(wderr), .cmp_evt_i(cmp_evt),
    .ap_rd_done_i(rd_done), .ap_rd_ok_i(rd_ok), .ap_rd_data_i(rd_data),
    .event_i(evt), .ap_abort_o(abort), .ap_sel_o(ap_sel), .ap_bank_o(ap_bank)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: reads return one cycle after the request
  always @(posedge clk) rd_pend <= req && !we;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [1:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic pulse_err(int which);
    @(negedge clk);
    case (which)
      0: overrun = 1;
      1: wderr = 1;
      2: ap_err = 1;
      default: cmp_evt = 1;
    endcase
    @(negedge clk);
    overrun = 0; wderr = 0; ap_err = 0; cmp_evt = 0;
  endtask

  task automatic ap_read(logic ok, logic [31:0] d);
    @(negedge clk);
    rd_done = 1; rd_ok = ok; rd_data = d;
    @(negedge clk);
    rd_done = 0; rd_ok = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 sys_req", {31'b0, sys_req}, 0);
    chk("R1 dbg_req", {31'b0, dbg_req}, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    chk("R1 abort", {31'b0, abort}, 0);
    chk("R1 ap_sel/bank", {20'b0, ap_sel, ap_bank}, 0);
    chk("R1 rdata", rdata, 0);
    rd(2'd1, 32'h0, "R1 ctrl after reset");
    rd(2'd2, 32'h0, "R1 select after reset");
    rd(2'd3, 32'h0, "R1 rdbuf after reset");
    // R2 id word with forced version
    rd(2'd0, {ID_V[31:16], 4'd2, ID_V[11:0]}, "R2 id word");

    // R5 requests and acks
    sys_ack = 1; rst_ack = 1;
    wr(2'd1, 32'h5400_0F05);
    chk("R5 sys_req", {31'b0, sys_req}, 1);
    chk("R5 dbg_req", {31'b0, dbg_req}, 1);
    chk("R5 rst_req", {31'b0, rst_req}, 1);
    rd(2'd1, 32'hDC00_0F05, "R5 ctrl readback");

    // R7 overrun gating
    wr(2'd1, 32'h5400_0F04);
    pulse_err(0);
    rd(2'd1, 32'hDC00_0F04, "R7 overrun while disabled");
    wr(2'd1, 32'h5400_0F05);
    pulse_err(0);
    rd(2'd1, 32'hDC00_0F07, "R7 overrun while enabled");

    // R6 event-set flags, writes ignored
    pulse_err(1); pulse_err(2); pulse_err(3);
    rd(2'd1, 32'hDC00_0FB7, "R6 flags set by events");
    wr(2'd1, 32'h5400_0FB7);
    rd(2'd1, 32'hDC00_0FB7, "R6 write ones to flags ignored");
    wr(2'd1, 32'h5400_0F05);
    rd(2'd1, 32'hDC00_0FB7, "R6 write zeros to flags ignored");

    // R3 abort clears
    wr(2'd0, 32'h0000_0004);
    chk("R4 no pulse without bit0", {31'b0, abort}, 0);
    rd(2'd1, 32'hDC00_0F97, "R3 clear error flag only");
    wr(2'd0, 32'h0000_001A);
    rd(2'd1, 32'hDC00_0F05, "R3 multi-flag clear");

    // R4 abort pulse
    wr(2'd0, 32'h0000_0001);
    chk("R4 abort pulse high", {31'b0, abort}, 1);
    @(negedge clk);
    chk("R4 abort pulse one cycle", {31'b0, abort}, 0);

    // R12 event wins over clear
    @(negedge clk);
    ap_err = 1; req = 1; we = 1; addr = 2'd0; wdata = 32'h4;
    @(negedge clk);
    ap_err = 0; req = 0; we = 0;
    rd(2'd1, 32'hDC00_0F25, "R12 set beats clear");
    wr(2'd0, 32'h4);
    rd(2'd1, 32'hDC00_0F05, "R12 later clear works");

    // R8 / R11 read status and read buffer
    ap_read(1'b1, 32'h1234_5678);
    rd(2'd1, 32'hDC00_0F45, "R8 read ok set");
    rd(2'd3, 32'h1234_5678, "R11 rdbuf first read");
    rd(2'd3, 32'h1234_5678, "R11 rdbuf repeat read");
    chk("R11 no abort from rdbuf read", {31'b0, abort}, 0);
    ap_read(1'b0, 32'hCAFE_0001);
    rd(2'd1, 32'hDC00_0F05, "R8 read ok cleared");
    rd(2'd3, 32'hCAFE_0001, "R11 rdbuf updated");

    // R10 select fields
    wr(2'd2, 32'hA5FF_FF30);
    chk("R10 ap_sel", {24'b0, ap_sel}, 32'hA5);
    chk("R10 ap_bank", {28'b0, ap_bank}, 32'h3);
    rd(2'd2, 32'hA500_0030, "R10 select readback");

    // R9 banked word
    wr(2'd2, 32'hA500_0031);
    rd(2'd1, 32'h0, "R9 link ctrl reset");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, LMASK, "R9 link ctrl masked write");
    wr(2'd2, 32'hA500_0032);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, TGT_V, "R9 target id");
    wr(2'd2, 32'hA500_0033);
    rd(2'd1, LID_V, "R9 link id");
    evt = 1;
    wr(2'd2, 32'hA500_0034);
    rd(2'd1, 32'h1, "R9 event status");
    wr(2'd2, 32'hA500_0035);
    rd(2'd1, 32'h0, "R9 reserved bank reads zero");
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R9 reserved bank write no req change", {29'b0, sys_req, dbg_req, rst_req}, 32'h7);
    wr(2'd2, 32'hA500_0030);
    dbg_ack = 1;
    rd(2'd1, 32'hFC00_0F05, "R9 ctrl untouched by other banks");
    wr(2'd2, 32'hA500_0031);
    rd(2'd1, LMASK, "R9 link ctrl kept through bank 2 write");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 reqs after reset", {29'b0, sys_req, dbg_req, rst_req}, 0);
    chk("R1 select after reset", {20'b0, ap_sel, ap_bank}, 0);
    rd(2'd1, 32'hA800_0000, "R1 ctrl after second reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drain", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule